// File: doc/BRIEF.md
# Looping Register Address Sequencer

This block steers the register address while a serial read runs on and on. The register map holds eleven 24-bit registers. Six channel result registers sit at 0x00 to 0x05, and five control registers sit at 0x06 to 0x0A. A read command supplies a start address. The serial shifter then sends one tick per transmitted bit. The sequencer tracks which bit of the current word is on the line. After the last bit of a word it moves to the next address, as the 2-bit read mode selects.

Result words can be short or full length. Each channel has a width input: when it is set the channel sends all 24 bits, and when it is clear it sends only the top 16 bits. Control registers always send 24 bits.

The sequencer also tells the result capture logic when to take a fresh snapshot of the channel results. It does this at every command, and at the loop points that the mode defines. Deasserting chip select returns everything to idle.

Top module: `reg_loop_sequencer`

## Requirements
- R1: A read command (`cmd_valid` high while `cs_n` is low) makes `reading` 1 on the next cycle, loads `reg_addr` with `cmd_addr`, and sets `bit_pos` to 23. A start address above 0x0A loads 0x00 instead. A command during a read restarts the read.
- R2: Every accepted command drives `relatch_req` high for exactly the one following cycle.
- R3: With `read_mode` = 2'b00 (static), `reg_addr` never changes during a read.
- R4: With `read_mode` = 2'b01 (group), a result register alternates with its partner in the pair {0x00,0x01}, {0x02,0x03} or {0x04,0x05}. A control register repeats itself.
- R5: With `read_mode` = 2'b10 (type), result addresses step 0x00..0x05 and wrap to 0x00, and control addresses step 0x06..0x0A and wrap to 0x06. In this mode and in static mode, `relatch_req` fires only for commands.
- R6: With `read_mode` = 2'b11 (full map), the address steps through 0x00..0x0A and then wraps to 0x00.
- R7: In group mode, `relatch_req` pulses for one cycle each time the address returns from the odd register of a result pair to the even one. In full-map mode, it pulses when the address wraps from 0x0A to 0x00.
- R8: `bit_pos` counts down once per `bit_tick`, starting at 23. The word ends at bit 0 for control registers and for result channel n when `width_sel[n]` is 1. It ends at bit 8 (16 bits sent) when `width_sel[n]` is 0. After the final bit, `bit_pos` returns to 23 and the address advances on that same tick.
- R9: `last_bit` is 1 exactly when `reading` is 1 and `bit_pos` equals the final bit position of the current word.
- R10: While `cs_n` is high, the state on the next cycle is idle: `reading` is 0, `reg_addr` is 0x00, `bit_pos` is 23 and `relatch_req` is 0. Commands and ticks are ignored.
- R11: When `reading` is 0, `bit_tick` has no effect. In cycles without a tick or a command, `reg_addr` and `bit_pos` hold.
- R12: After reset the outputs show the idle state of R10, with `last_bit` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; high forces idle |
| cmd_valid | input | 1 | One-cycle strobe of a decoded read command |
| cmd_addr | input | 4 | Start address carried by the command |
| bit_tick | input | 1 | One bit of the current word has been shifted |
| read_mode | input | 2 | Address loop mode: 00 static, 01 group, 10 type, 11 full map |
| width_sel | input | 6 | Per result channel: 1 = 24-bit word, 0 = 16-bit word |
| reg_addr | output | 4 | Register currently being read |
| bit_pos | output | 5 | Bit of the 24-bit register now on the line, 23 = MSB |
| last_bit | output | 1 | The current bit ends the word |
| reading | output | 1 | A read is in progress |
| relatch_req | output | 1 | One-cycle request to re-capture channel results |

## Verification
The bench builds the block with its default parameters: six result channels, five control registers, 24-bit words and 16-bit short words. With these values the 4-bit address field has five unused codes above 0x0A, so start-address clamping can be exercised. Every wrap point of all four modes is also within reach of reads that last a few dozen words. The random width masks mix 16-bit and 24-bit channels within a single type loop, so short and long words follow each other across pair boundaries and across the 0x05 wrap.

// File: rtl/seq_pkg.sv
package seq_pkg;

    // Default geometry of the register map
    localparam int DEF_NUM_RESULT = 6;
    localparam int DEF_NUM_CTRL   = 5;
    localparam int DEF_WORD_BITS  = 24;
    localparam int DEF_SHORT_BITS = 16;

    // Address loop modes
    typedef enum logic [1:0] {
        MODE_STATIC = 2'b00,
        MODE_GROUP  = 2'b01,
        MODE_TYPE   = 2'b10,
        MODE_FULL   = 2'b11
    } read_mode_e;

endpackage

// File: rtl/seq_addr_step.sv
module seq_addr_step
    import seq_pkg::*;
#(
    parameter int NUM_RESULT = DEF_NUM_RESULT,
    parameter int NUM_CTRL   = DEF_NUM_CTRL,
    parameter int ADDR_W     = $clog2(DEF_NUM_RESULT + DEF_NUM_CTRL)
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  read_mode_e        mode,
    output logic [ADDR_W-1:0] next_addr,
    output logic              relatch_hit
);

    localparam logic [ADDR_W-1:0] LAST_ADDR  = ADDR_W'(NUM_RESULT + NUM_CTRL - 1);
    localparam logic [ADDR_W-1:0] LAST_RES   = ADDR_W'(NUM_RESULT - 1);
    localparam logic [ADDR_W-1:0] FIRST_CTRL = ADDR_W'(NUM_RESULT);

    logic is_result;

    always_comb begin
        is_result   = (cur_addr < FIRST_CTRL);
        next_addr   = cur_addr;
        relatch_hit = 1'b0;
        case (mode)
            MODE_STATIC: begin
                next_addr = cur_addr;
            end
            MODE_GROUP: begin
                if (is_result) begin
                    // pairs are {even, odd}; the odd member folds back
                    next_addr   = cur_addr[0] ? (cur_addr - 1'b1) : (cur_addr + 1'b1);
                    relatch_hit = cur_addr[0];
                end
            end
            MODE_TYPE: begin
                if (is_result)
                    next_addr = (cur_addr == LAST_RES) ? '0 : (cur_addr + 1'b1);
                else
                    next_addr = (cur_addr == LAST_ADDR) ? FIRST_CTRL : (cur_addr + 1'b1);
            end
            MODE_FULL: begin
                next_addr   = (cur_addr == LAST_ADDR) ? '0 : (cur_addr + 1'b1);
                relatch_hit = (cur_addr == LAST_ADDR);
            end
            default: next_addr = cur_addr;
        endcase
    end

endmodule

// File: rtl/seq_word_len.sv
module seq_word_len #(
    parameter int NUM_RESULT = 6,
    parameter int ADDR_W     = 4,
    parameter int POS_W      = 5,
    parameter int WORD_BITS  = 24,
    parameter int SHORT_BITS = 16
) (
    input  logic [ADDR_W-1:0]     cur_addr,
    input  logic [NUM_RESULT-1:0] width_sel,
    output logic [POS_W-1:0]      last_pos
);

    localparam logic [POS_W-1:0] SHORT_LAST = POS_W'(WORD_BITS - SHORT_BITS);

    logic [NUM_RESULT-1:0] short_hit;

    for (genvar g = 0; g < NUM_RESULT; g++) begin : g_chan
        assign short_hit[g] = (cur_addr == ADDR_W'(g)) && !width_sel[g];
    end

    assign last_pos = (|short_hit) ? SHORT_LAST : '0;

endmodule

// File: rtl/reg_loop_sequencer.sv
module reg_loop_sequencer
    import seq_pkg::*;
#(
    parameter  int NUM_RESULT = DEF_NUM_RESULT,
    parameter  int NUM_CTRL   = DEF_NUM_CTRL,
    parameter  int WORD_BITS  = DEF_WORD_BITS,
    parameter  int SHORT_BITS = DEF_SHORT_BITS,
    localparam int ADDR_W     = $clog2(NUM_RESULT + NUM_CTRL),
    localparam int POS_W      = $clog2(WORD_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  cmd_valid,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic                  bit_tick,
    input  logic [1:0]            read_mode,
    input  logic [NUM_RESULT-1:0] width_sel,
    output logic [ADDR_W-1:0]     reg_addr,
    output logic [POS_W-1:0]      bit_pos,
    output logic                  last_bit,
    output logic                  reading,
    output logic                  relatch_req
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_RESULT + NUM_CTRL - 1);
    localparam logic [POS_W-1:0]  TOP_POS   = POS_W'(WORD_BITS - 1);

    typedef struct packed {
        logic              reading;
        logic [ADDR_W-1:0] addr;
        logic [POS_W-1:0]  pos;
        logic              relatch;
    } seq_state_t;

    localparam seq_state_t IDLE_STATE = '{reading: 1'b0, addr: '0, pos: TOP_POS, relatch: 1'b0};

    seq_state_t        state_d, state_q;
    logic [ADDR_W-1:0] step_addr;
    logic              step_hit;
    logic [POS_W-1:0]  last_pos;

    seq_addr_step #(
        .NUM_RESULT (NUM_RESULT),
        .NUM_CTRL   (NUM_CTRL),
        .ADDR_W     (ADDR_W)
    ) i_step (
        .cur_addr    (state_q.addr),
        .mode        (read_mode_e'(read_mode)),
        .next_addr   (step_addr),
        .relatch_hit (step_hit)
    );

    seq_word_len #(
        .NUM_RESULT (NUM_RESULT),
        .ADDR_W     (ADDR_W),
        .POS_W      (POS_W),
        .WORD_BITS  (WORD_BITS),
        .SHORT_BITS (SHORT_BITS)
    ) i_len (
        .cur_addr  (state_q.addr),
        .width_sel (width_sel),
        .last_pos  (last_pos)
    );

    always_comb begin
        state_d         = state_q;
        state_d.relatch = 1'b0;
        if (cs_n) begin
            state_d = IDLE_STATE;
        end else if (cmd_valid) begin
            state_d.reading = 1'b1;
            state_d.addr    = (cmd_addr > LAST_ADDR) ? '0 : cmd_addr;
            state_d.pos     = TOP_POS;
            state_d.relatch = 1'b1;
        end else if (bit_tick && state_q.reading) begin
            if (state_q.pos == last_pos) begin
                state_d.addr    = step_addr;
                state_d.pos     = TOP_POS;
                state_d.relatch = step_hit;
            end else begin
                state_d.pos = state_q.pos - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDLE_STATE;
        else        state_q <= state_d;
    end

    assign reg_addr    = state_q.addr;
    assign bit_pos     = state_q.pos;
    assign reading     = state_q.reading;
    assign relatch_req = state_q.relatch;
    assign last_bit    = state_q.reading && (state_q.pos == last_pos);

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int NUM_RESULT = 6,
    parameter int NUM_CTRL   = 5,
    parameter int ADDR_W     = 4,
    parameter int POS_W      = 5,
    parameter int WORD_BITS  = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_n,
    input logic                  cmd_valid,
    input logic                  bit_tick,
    input logic [1:0]            read_mode,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic [POS_W-1:0]      bit_pos,
    input logic                  last_bit,
    input logic                  reading,
    input logic                  relatch_req
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_RESULT + NUM_CTRL - 1);
    localparam logic [POS_W-1:0]  TOP_POS   = POS_W'(WORD_BITS - 1);

    // R1: an accepted command starts a read at the top bit and requests a snapshot
    a_r1_cmd_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && cmd_valid) |=> (reading && bit_pos == TOP_POS && relatch_req));

    // R2: a snapshot request always has a command or a tick as its cause
    a_r2_relatch_cause: assert property (@(posedge clk) disable iff (!rst_n)
        relatch_req |-> $past(!cs_n && (cmd_valid || bit_tick)));

    // R3: static mode never moves the address
    a_r3_static_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !cmd_valid && read_mode == 2'b00) |=> $stable(reg_addr));

    // R6: the address never leaves the map
    a_r6_addr_in_map: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr <= LAST_ADDR);

    // R9: the end-of-word flag only appears during a read
    a_r9_last_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        last_bit |-> reading);

    // R10: deselect returns to idle
    a_r10_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!reading && reg_addr == '0 && bit_pos == TOP_POS && !relatch_req));

    // R11: no tick and no command means no movement
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !cmd_valid && !bit_tick) |=> ($stable(reg_addr) && $stable(bit_pos)));

endmodule

bind reg_loop_sequencer seq_checker #(
    .NUM_RESULT (NUM_RESULT),
    .NUM_CTRL   (NUM_CTRL),
    .ADDR_W     (ADDR_W),
    .POS_W      (POS_W),
    .WORD_BITS  (WORD_BITS)
) i_seq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .cmd_valid   (cmd_valid),
    .bit_tick    (bit_tick),
    .read_mode   (read_mode),
    .reg_addr    (reg_addr),
    .bit_pos     (bit_pos),
    .last_bit    (last_bit),
    .reading     (reading),
    .relatch_req (relatch_req)
);

// File: tb/test_reg_loop_sequencer.sv
module test_reg_loop_sequencer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_addr = '0;
    logic       bit_tick = 1'b0;
    logic [1:0] read_mode = 2'b10;
    logic [5:0] width_sel = '0;
    logic [3:0] reg_addr;
    logic [4:0] bit_pos;
    logic       last_bit;
    logic       reading;
    logic       relatch_req;

    int n_checks = 0;
    int n_fail   = 0;

    // reference state
    int m_reading = 0;
    int m_addr    = 0;
    int m_pos     = 23;
    int m_rel     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_loop_sequencer i_reg_loop_sequencer (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
        .cmd_addr(cmd_addr), .bit_tick(bit_tick), .read_mode(read_mode),
        .width_sel(width_sel), .reg_addr(reg_addr), .bit_pos(bit_pos),
        .last_bit(last_bit), .reading(reading), .relatch_req(relatch_req)
    );

    function automatic int ref_final(input int a, input logic [5:0] w);
        if (a < 6 && !w[a]) return 8;
        return 0;
    endfunction

    function automatic int ref_next(input int a, input int mode);
        case (mode)
            0: return a;
            1: begin
                if (a >= 6) return a;
                return (a % 2 == 1) ? a - 1 : a + 1;
            end
            2: begin
                if (a == 5)  return 0;
                if (a == 10) return 6;
                return a + 1;
            end
            default: return (a == 10) ? 0 : a + 1;
        endcase
    endfunction

    function automatic int ref_loop_relatch(input int a, input int mode);
        if (mode == 1) return (a < 6 && a % 2 == 1) ? 1 : 0;
        if (mode == 3) return (a == 10) ? 1 : 0;
        return 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string t_addr, input string t_pos, input string t_rel);
        check(t_addr, int'(reading), m_reading, "reading");
        check(t_addr, int'(reg_addr), m_addr, "reg_addr");
        check(t_pos, int'(bit_pos), m_pos, "bit_pos");
        check(t_rel, int'(relatch_req), m_rel, "relatch_req");
        check("R9", int'(last_bit),
              (m_reading != 0 && m_pos == ref_final(m_addr, width_sel)) ? 1 : 0, "last_bit");
    endtask

    // One clock with the given strobes; model update and compare at the next negedge
    task automatic step(input logic c, input logic t);
        string ta, tp, tr;
        @(negedge clk);
        cmd_valid = c;
        bit_tick  = t;
        @(negedge clk);
        cmd_valid = 1'b0;
        bit_tick  = 1'b0;
        ta = "R11"; tp = "R11"; tr = "R11";
        m_rel = 0;
        if (cs_n) begin
            m_reading = 0; m_addr = 0; m_pos = 23;
            ta = "R10"; tp = "R10"; tr = "R10";
        end else if (c) begin
            m_reading = 1;
            m_addr = (int'(cmd_addr) > 10) ? 0 : int'(cmd_addr);
            m_pos = 23; m_rel = 1;
            ta = "R1"; tp = "R1"; tr = "R2";
        end else if (t && m_reading != 0) begin
            tp = "R8";
            case (read_mode)
                2'b00: begin ta = "R3"; tr = "R5"; end
                2'b01: begin ta = "R4"; tr = "R7"; end
                2'b10: begin ta = "R5"; tr = "R5"; end
                default: begin ta = "R6"; tr = "R7"; end
            endcase
            if (m_pos == ref_final(m_addr, width_sel)) begin
                m_rel  = ref_loop_relatch(m_addr, int'(read_mode));
                m_addr = ref_next(m_addr, int'(read_mode));
                m_pos  = 23;
            end else begin
                m_pos = m_pos - 1;
            end
        end
        compare_all(ta, tp, tr);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", int'(reading), 0, "reading");
        check("R12", int'(reg_addr), 0, "reg_addr");
        check("R12", int'(bit_pos), 23, "bit_pos");
        check("R12", int'(relatch_req), 0, "relatch_req");
        check("R12", int'(last_bit), 0, "last_bit");
        rst_n = 1'b1;

        // R10: commands ignored while deselected
        cmd_addr = 4'd3;
        step(1'b1, 1'b0);
        // R11: ticks ignored while idle
        cs_n = 1'b0;
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);

        // R1: out-of-map start clamps to 0x00; R8 short word of 16 ticks
        read_mode = 2'b01; width_sel = 6'b000000; cmd_addr = 4'd15;
        step(1'b1, 1'b0);
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1);

        // R7: group loop on pair {2,3} with mixed widths
        width_sel = 6'b000100; cmd_addr = 4'd3;
        step(1'b1, 1'b0);
        for (int i = 0; i < 90; i++) step(1'b0, 1'b1);

        // R6/R7: full-map wrap from 0x0A with 24-bit control words
        read_mode = 2'b11; cmd_addr = 4'd10;
        step(1'b1, 1'b0);
        for (int i = 0; i < 60; i++) step(1'b0, 1'b1);

        // R10: deselect in mid-word, then a command restarts cleanly
        cs_n = 1'b1;
        step(1'b0, 1'b1);
        cs_n = 1'b0;
        read_mode = 2'b10; cmd_addr = 4'd9;
        step(1'b1, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1);
        // R1: new command in the middle of a read restarts it
        cmd_addr = 4'd4;
        step(1'b1, 1'b0);
        for (int i = 0; i < 70; i++) step(1'b0, 1'b1);

        // random reads
        for (int r = 0; r < 80; r++) begin
            cs_n      = 1'b0;
            read_mode = 2'($urandom_range(0, 3));
            width_sel = 6'($urandom);
            cmd_addr  = 4'($urandom_range(0, 15));
            step(1'b1, 1'b0);
            for (int i = 0; i < int'($urandom_range(20, 160)); i++)
                step(1'b0, ($urandom_range(0, 3) != 0));
            if ($urandom_range(0, 1) == 1) begin
                cs_n = 1'b1;
                step(1'b0, 1'b1);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule